// File: doc/BRIEF.md
# Quarter-Rate Quadrature Correlator with Sliding Window

This block demodulates a carrier that is sampled at exactly four times its frequency. Each run of four valid samples is one carrier period. The block mixes that run against fixed sine and cosine patterns. At this sample rate the patterns hold only +1, 0 and -1, so mixing needs no multiplier. The result is one in-phase total and one quadrature total per period.

Each of the two totals feeds its own 120-deep ring. A running sum is kept beside each ring. The running sums are the windowed in-phase and quadrature values. A small sequencer then derives two values from them:
- an integer magnitude, from a bit-serial square root;
- a normalised phase, from a bit-serial divider: the quadrature sum divided by the magnitude.

All four results are published together with a one-clock strobe. Before the ring has been filled once, a flag marks the results as partial.

The sequencer has four states. IDLE waits for the window update and takes a copy of both sums. This IDLE->ROOT step also starts the square root. In ROOT, a finished root with a value of zero goes ROOT->PUBLISH. Any other finished root goes ROOT->DIVIDE and starts the divider. When the divider finishes, the state goes DIVIDE->PUBLISH. PUBLISH drives the outputs for one clock and then goes PUBLISH->IDLE.

The full computation takes about 60 clocks. The sample source must therefore leave at least 64 clocks between the last sample of one period and the last sample of the next.

Top module: `iq_window_corr`

## Requirements
- R1: While reset is held and right after its release, res_stb and res_full are 0 and res_i, res_q, res_mag, res_phase are all 0.
- R2: Only clocks with smp_valid high take a sample, and smp_data on other clocks has no effect. The first valid sample after reset is position 0 of a period, and positions run 0, 1, 2, 3 and then repeat.
- R3: Per period, the in-phase total is s0 - s2 and the quadrature total is s1 - s3, where sN is the two's-complement sample at position N.
- R4: res_i and res_q are the sums of the in-phase and quadrature totals of the most recent min(n, 120) periods, where n is the number of periods since reset. Older periods leave the sum completely.
- R5: res_mag equals floor(sqrt(res_i^2 + res_q^2)).
- R6: res_phase equals res_q * 16384 / res_mag, truncated toward zero, as a signed value. It is 0 when res_mag is 0, and it always lies in -16384..16384.
- R7: res_stb pulses high for exactly one clock per period. It rises no more than 64 clocks after the clock edge that took sample 3. The four result outputs change only together with that pulse.
- R8: res_full is 0 for the results of periods 1 to 119. It is 1 from the result of period 120 onward, and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 12 | Signed sample |
| res_stb | output | 1 | One-clock pulse when new results are out |
| res_full | output | 1 | Window has been filled once since reset |
| res_i | output | 20 | Windowed in-phase sum, signed |
| res_q | output | 20 | Windowed quadrature sum, signed |
| res_mag | output | 20 | Magnitude of the two sums, unsigned |
| res_phase | output | 16 | Quadrature sum over magnitude, 14 fraction bits, signed |

## Verification
The bench drives junk data on invalid clocks. A design that latched data without smp_valid, or that slipped the position counter, would show wrong totals at once.

Three fill patterns test the window:
- a fill across the 120-period boundary;
- a long run of full-scale periods;
- a long run of zero periods.

A design that forgot to subtract the retired entry, or that lost a carry in the 20-bit sums, would leave a nonzero or wrapped result.

Pure-sine windows push the phase to exactly +16384 and -16384. Pure-cosine and all-zero windows test the zero cases: zero quadrature, and zero magnitude. A design that got any of these wrong would show an off-by-one quotient, a flipped sign, or a division by zero.

// File: rtl/iqw_pkg.sv
package iqw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ROOT,
        ST_DIVIDE,
        ST_PUBLISH
    } iqw_state_t;

    localparam int NUM_CHAN = 2;
endpackage

// File: rtl/iqw_mixer.sv
module iqw_mixer #(
    parameter int SMP_W = 12,
    parameter int TOT_W = SMP_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic [SMP_W-1:0]        smp_data,
    output logic                    cyc_stb,
    output logic signed [TOT_W-1:0] cyc_i,
    output logic signed [TOT_W-1:0] cyc_q
);
    logic [1:0]              pos;
    logic signed [TOT_W-1:0] acc_i;
    logic signed [TOT_W-1:0] acc_q;
    logic signed [TOT_W-1:0] x_ext;

    assign x_ext = {{(TOT_W-SMP_W){smp_data[SMP_W-1]}}, smp_data};

    // cosine pattern +1,0,-1,0 ; sine pattern 0,+1,0,-1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos     <= '0;
            acc_i   <= '0;
            acc_q   <= '0;
            cyc_i   <= '0;
            cyc_q   <= '0;
            cyc_stb <= 1'b0;
        end else begin
            cyc_stb <= 1'b0;
            if (smp_valid) begin
                pos <= pos + 2'd1;
                unique case (pos)
                    2'd0: acc_i <= x_ext;
                    2'd1: acc_q <= x_ext;
                    2'd2: acc_i <= acc_i - x_ext;
                    2'd3: begin
                        cyc_i   <= acc_i;
                        cyc_q   <= acc_q - x_ext;
                        cyc_stb <= 1'b1;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/iqw_window.sv
module iqw_window #(
    parameter int TOT_W = 13,
    parameter int DEPTH = 120,
    parameter int SUM_W = 20
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_stb,
    input  logic signed [TOT_W-1:0] in_val,
    output logic signed [SUM_W-1:0] win_sum,
    output logic                    out_stb,
    output logic                    full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic signed [TOT_W-1:0] ring [DEPTH];
    logic [PTR_W-1:0]        wptr;
    logic signed [TOT_W-1:0] oldest;
    logic signed [SUM_W-1:0] new_ext;
    logic signed [SUM_W-1:0] old_ext;

    assign oldest  = ring[wptr];
    assign new_ext = {{(SUM_W-TOT_W){in_val[TOT_W-1]}}, in_val};
    assign old_ext = {{(SUM_W-TOT_W){oldest[TOT_W-1]}}, oldest};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) ring[k] <= '0;
            wptr    <= '0;
            win_sum <= '0;
            out_stb <= 1'b0;
            full    <= 1'b0;
        end else begin
            out_stb <= in_stb;
            if (in_stb) begin
                ring[wptr] <= in_val;
                win_sum    <= win_sum + new_ext - old_ext;
                wptr       <= (wptr == LAST) ? '0 : wptr + 1'b1;
                if (wptr == LAST) full <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/iqw_isqrt.sv
module iqw_isqrt #(
    parameter int RAD_W  = 40,
    parameter int ROOT_W = RAD_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RAD_W-1:0]  radicand,
    output logic              done,
    output logic [ROOT_W-1:0] root
);
    logic [RAD_W-1:0] op;
    logic [RAD_W-1:0] res;
    logic [RAD_W-1:0] one;
    logic [RAD_W-1:0] trial;
    logic             run;

    assign trial = res + one;
    assign root  = res[ROOT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op   <= '0;
            res  <= '0;
            one  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                op  <= radicand;
                res <= '0;
                one <= RAD_W'(1) << (RAD_W - 2);
                run <= 1'b1;
            end else if (run) begin
                if (op >= trial) begin
                    op  <= op - trial;
                    res <= (res >> 1) + one;
                end else begin
                    res <= res >> 1;
                end
                one <= one >> 2;
                if (one == RAD_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/iqw_divide.sv
module iqw_divide #(
    parameter int NUM_W = 34,
    parameter int DEN_W = 20,
    parameter int Q_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quo_out
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_r;
    logic [NUM_W-1:0] quo;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [DEN_W:0]   shifted;
    logic             ge;
    logic [DEN_W-1:0] rem_n;

    assign shifted = {rem, quo[NUM_W-1]};
    assign ge      = shifted >= {1'b0, den_r};
    assign rem_n   = DEN_W'(ge ? (shifted - {1'b0, den_r}) : shifted);
    assign quo_out = quo[Q_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            den_r <= '0;
            quo   <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem   <= '0;
                den_r <= den;
                quo   <= num;
                cnt   <= CNT_W'(NUM_W);
                run   <= 1'b1;
            end else if (run) begin
                rem <= rem_n;
                quo <= {quo[NUM_W-2:0], ge};
                cnt <= cnt - 1'b1;
                if (cnt == CNT_W'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/iq_window_corr.sv
module iq_window_corr #(
    parameter int SMP_W   = 12,
    parameter int WIN_LEN = 120,
    parameter int FRAC_W  = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         smp_valid,
    input  logic [SMP_W-1:0]             smp_data,
    output logic                         res_stb,
    output logic                         res_full,
    output logic signed [SMP_W+$clog2(WIN_LEN):0] res_i,
    output logic signed [SMP_W+$clog2(WIN_LEN):0] res_q,
    output logic [SMP_W+$clog2(WIN_LEN):0]        res_mag,
    output logic signed [FRAC_W+1:0]     res_phase
);
    import iqw_pkg::*;

    localparam int TOT_W = SMP_W + 1;
    localparam int SUM_W = TOT_W + $clog2(WIN_LEN);
    localparam int RAD_W = 2 * SUM_W;
    localparam int NUM_W = SUM_W + FRAC_W;
    localparam int PH_W  = FRAC_W + 2;

    logic                    cyc_stb;
    logic signed [TOT_W-1:0] cyc_tot [NUM_CHAN];
    logic signed [SUM_W-1:0] wsum    [NUM_CHAN];
    logic [NUM_CHAN-1:0]     wstb;
    logic [NUM_CHAN-1:0]     wfull;
    logic                    win_stb;
    logic                    win_full;

    iqw_mixer #(.SMP_W(SMP_W), .TOT_W(TOT_W)) u_mixer (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .cyc_stb   (cyc_stb),
        .cyc_i     (cyc_tot[0]),
        .cyc_q     (cyc_tot[1])
    );

    generate
        for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
            iqw_window #(.TOT_W(TOT_W), .DEPTH(WIN_LEN), .SUM_W(SUM_W)) u_win (
                .clk     (clk),
                .rst_n   (rst_n),
                .in_stb  (cyc_stb),
                .in_val  (cyc_tot[c]),
                .win_sum (wsum[c]),
                .out_stb (wstb[c]),
                .full    (wfull[c])
            );
        end
    endgenerate

    assign win_stb  = &wstb;
    assign win_full = &wfull;

    // squared magnitude of the fresh window sums
    logic signed [RAD_W-1:0] ext_i, ext_q;
    logic signed [RAD_W-1:0] sq_sum;
    logic [RAD_W-1:0]        radicand;

    assign ext_i    = {{SUM_W{wsum[0][SUM_W-1]}}, wsum[0]};
    assign ext_q    = {{SUM_W{wsum[1][SUM_W-1]}}, wsum[1]};
    assign sq_sum   = ext_i * ext_i + ext_q * ext_q;
    assign radicand = sq_sum;

    iqw_state_t              state, state_n;
    logic signed [SUM_W-1:0] lat_i, lat_q;
    logic [SUM_W-1:0]        lat_mag;
    logic [SUM_W-1:0]        abs_q;
    logic                    root_start, root_done;
    logic [SUM_W-1:0]        root;
    logic                    div_start, div_done;
    logic [PH_W-1:0]         div_quo;
    logic [NUM_W-1:0]        div_num;

    assign abs_q      = lat_q[SUM_W-1] ? SUM_W'(-lat_q) : SUM_W'(lat_q);
    assign div_num    = {abs_q, {FRAC_W{1'b0}}};
    assign root_start = (state == ST_IDLE) && win_stb;
    assign div_start  = (state == ST_ROOT) && root_done && (root != '0);

    iqw_isqrt #(.RAD_W(RAD_W), .ROOT_W(SUM_W)) u_root (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (root_start),
        .radicand (radicand),
        .done     (root_done),
        .root     (root)
    );

    iqw_divide #(.NUM_W(NUM_W), .DEN_W(SUM_W), .Q_W(PH_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (div_start),
        .num     (div_num),
        .den     (root),
        .done    (div_done),
        .quo_out (div_quo)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:    if (win_stb) state_n = ST_ROOT;
            ST_ROOT:    if (root_done) state_n = (root == '0) ? ST_PUBLISH : ST_DIVIDE;
            ST_DIVIDE:  if (div_done) state_n = ST_PUBLISH;
            ST_PUBLISH: state_n = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_i     <= '0;
            lat_q     <= '0;
            lat_mag   <= '0;
            res_stb   <= 1'b0;
            res_full  <= 1'b0;
            res_i     <= '0;
            res_q     <= '0;
            res_mag   <= '0;
            res_phase <= '0;
        end else begin
            res_stb <= 1'b0;
            if (root_start) begin
                lat_i <= wsum[0];
                lat_q <= wsum[1];
            end
            if (state == ST_ROOT && root_done) lat_mag <= root;
            if (state == ST_PUBLISH) begin
                res_stb  <= 1'b1;
                res_full <= win_full;
                res_i    <= lat_i;
                res_q    <= lat_q;
                res_mag  <= lat_mag;
                if (lat_mag == '0)        res_phase <= '0;
                else if (lat_q[SUM_W-1])  res_phase <= -$signed(div_quo);
                else                      res_phase <= $signed(div_quo);
            end
        end
    end
endmodule

// File: rtl/iq_window_corr_chk.sv
module iq_window_corr_chk #(
    parameter int SUM_W  = 20,
    parameter int FRAC_W = 14,
    parameter int PH_W   = FRAC_W + 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    res_stb,
    input logic                    res_full,
    input logic signed [SUM_W-1:0] res_i,
    input logic signed [SUM_W-1:0] res_q,
    input logic [SUM_W-1:0]        res_mag,
    input logic signed [PH_W-1:0]  res_phase
);
    localparam int PH_ONE = 1 << FRAC_W;

    logic [SUM_W-1:0] mag_i, mag_q;
    assign mag_i = res_i[SUM_W-1] ? SUM_W'(-res_i) : SUM_W'(res_i);
    assign mag_q = res_q[SUM_W-1] ? SUM_W'(-res_q) : SUM_W'(res_q);

    // R7
    stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb |=> !res_stb);

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !res_stb |-> ($stable(res_i) && $stable(res_q) && $stable(res_mag) && $stable(res_phase)));

    // R8
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_full |=> res_full);

    // R5
    mag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb |-> (res_mag >= mag_i && res_mag >= mag_q));

    // R6
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_stb |-> (int'(res_phase) <= PH_ONE && int'(res_phase) >= -PH_ONE));

    // R6
    phase_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_stb && res_q < 0) |-> res_phase <= 0);

    // R6
    phase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_stb && res_mag == '0) |-> res_phase == '0);
endmodule

bind iq_window_corr iq_window_corr_chk #(.SUM_W(SUM_W), .FRAC_W(FRAC_W), .PH_W(PH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_stb   (res_stb),
    .res_full  (res_full),
    .res_i     (res_i),
    .res_q     (res_q),
    .res_mag   (res_mag),
    .res_phase (res_phase)
);

// File: tb/iq_window_corr_bench.sv
`timescale 1ns/1ps
module iq_window_corr_bench;
    localparam int WIN = 120;
    localparam int GAP = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_data = '0;
    logic        res_stb, res_full;
    logic signed [19:0] res_i, res_q;
    logic [19:0] res_mag;
    logic signed [15:0] res_phase;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;
    int hist_i [0:1023];
    int hist_q [0:1023];

    always #10 clk = ~clk;

    iq_window_corr u_iq_window_corr (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .res_stb(res_stb), .res_full(res_full), .res_i(res_i), .res_q(res_q),
        .res_mag(res_mag), .res_phase(res_phase)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, n_cyc, act, exp);
        end
    endtask

    function automatic longint isqrt(input longint x);
        longint lo = 0, hi = 1 << 21, mid;
        while (hi - lo > 1) begin
            mid = (lo + hi) / 2;
            if (mid * mid <= x) lo = mid; else hi = mid;
        end
        return lo;
    endfunction

    function automatic int junk();
        return int'($urandom_range(0, 4095));
    endfunction

    task automatic run_cycle(input int s0, input int s1, input int s2, input int s3);
        int s [4];
        int lat;
        longint ei, eq, em, ep, aq;
        s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = 12'(s[k]);
            @(negedge clk);
            smp_valid = 1'b0;
            smp_data  = 12'(junk());
            if (k < 3) repeat (GAP) @(negedge clk);
        end
        lat = 1;
        while (!res_stb && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        hist_i[n_cyc] = s0 - s2;
        hist_q[n_cyc] = s1 - s3;
        n_cyc++;
        ei = 0; eq = 0;
        for (int j = (n_cyc > WIN ? n_cyc - WIN : 0); j < n_cyc; j++) begin
            ei += hist_i[j];
            eq += hist_q[j];
        end
        em = isqrt(ei * ei + eq * eq);
        aq = eq < 0 ? -eq : eq;
        ep = (em == 0) ? 0 : (aq * 16384) / em;
        if (eq < 0) ep = -ep;
        chk("R7 latency", (lat <= 64) ? 1 : 0, 1);
        chk("R7 strobe", longint'(res_stb), 1);
        chk("R2 R3 R4 window I", longint'(res_i), ei);
        chk("R2 R3 R4 window Q", longint'(res_q), eq);
        chk("R5 magnitude", longint'(res_mag), em);
        chk("R6 phase", longint'(res_phase), ep);
        chk("R8 full flag", longint'(res_full), (n_cyc >= WIN) ? 1 : 0);
        @(negedge clk);
        chk("R7 single pulse", longint'(res_stb), 0);
    endtask

    function automatic int rnd_smp();
        return int'($urandom_range(0, 4095)) - 2048;
    endfunction

    initial begin
        void'($urandom(32'h1d0c_7a55));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 stb", longint'(res_stb), 0);
        chk("R1 full", longint'(res_full), 0);
        chk("R1 mag", longint'(res_mag), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 i", longint'(res_i), 0);
        chk("R1 q", longint'(res_q), 0);
        chk("R1 phase", longint'(res_phase), 0);

        // pure cosine: zero quadrature, R6 phase 0
        for (int c = 0; c < 3; c++) run_cycle(500, 0, -500, 0);
        // random fill across the window boundary
        for (int c = 0; c < 125; c++) run_cycle(rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp());
        // full-scale periods: widest sums
        for (int c = 0; c < WIN; c++) run_cycle(2047, 2047, -2048, -2048);
        // negative pure sine: phase reaches -16384
        for (int c = 0; c < WIN; c++) run_cycle(0, -2048, 0, 2047);
        // positive pure sine: phase reaches +16384
        for (int c = 0; c < WIN; c++) run_cycle(0, 1500, 0, -1500);
        // all zero: magnitude 0, old entries retired
        for (int c = 0; c < WIN; c++) run_cycle(0, 0, 0, 0);
        // random tail
        for (int c = 0; c < 20; c++) run_cycle(rnd_smp(), rnd_smp(), rnd_smp(), rnd_smp());

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule